// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an addressing-mode request from a small 16-bit processor into a 16-bit effective address. It handles five modes: register indirect with pre-decrement, short absolute in the top page of memory, long absolute, branch targets relative to the program counter, and branch targets fetched indirectly through a pointer in the bottom page of memory. The decoder presents one request at a time. Each request carries a mode code, a byte/word size flag, the current register value, the instruction field and the program counter.

The four direct modes give a registered result one cycle after the request is accepted. In pre-decrement mode the result also carries the new register value for write-back. Memory-indirect mode reads a pointer word through a simple request/acknowledge port. The result then follows one cycle after the acknowledge. While that read is open, the block holds `busy` and ignores any further requests. All arithmetic wraps modulo 2^16 and raises no flag.

Top module: `opnd_ea_unit`

## Requirements
- R1: Mode code 0 (pre-decrement) sets `res_reg_wb` to `req_reg` minus 1 for a byte or minus 2 for a word, asserts `res_wb_en`, and uses that decremented value as `res_addr`.
- R2: Mode code 1 (short absolute) gives `res_addr` = {0xFF, `req_field[7:0]`}, so every address lies in 0xFF00..0xFFFF.
- R3: Mode code 2 (long absolute) gives `res_addr` = `req_field[15:0]`.
- R4: Mode code 3 (PC-relative) gives `res_addr` = `req_pc` + sign-extended `req_field[7:0]`. With `req_pc` two bytes past the instruction start, this reaches −126..+128 bytes from the instruction.
- R5: Mode code 4 (memory indirect) drives `mem_rd_addr` = {0x00, `req_field[7:1]`, 0} and holds `mem_rd_req` and `mem_rd_addr` steady until `mem_rd_ack`. `mem_rd_data` is the big-endian word at that even address, with the byte at the even address as bits 15:8. Its value, with bit 0 cleared, becomes `res_addr` in the cycle after the acknowledge edge.
- R6: Bit 0 of `res_addr` is forced to 0 for every word-sized access (`req_word`=1) and for every branch target (modes 3 and 4). For byte accesses in modes 0..2 it is left as computed.
- R7: A direct-mode request accepted at a clock edge gives `res_valid` high for exactly the following cycle. `res_wb_en` is high only with a mode-0 result.
- R8: From the edge that accepts a mode-4 request until its result cycle, inclusive, `busy` is high and requests are ignored: they produce no result and no read.
- R9: Mode codes 5..7 produce no result, no write-back and no memory read.
- R10: After reset, `res_valid`, `res_wb_en`, `busy` and `mem_rd_req` are 0.
- R11: Address and register arithmetic wraps modulo 2^16 (for example, a byte pre-decrement of 0x0000 gives 0xFFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Mode code (0..4 defined) |
| req_word | input | 1 | 1 = word operand, 0 = byte operand |
| req_reg | input | 16 | Current value of the selected register |
| req_field | input | 16 | Instruction field (8-bit modes use bits 7:0) |
| req_pc | input | 16 | Program counter, two bytes past the instruction start |
| res_valid | output | 1 | Result strobe |
| res_addr | output | 16 | Effective address |
| res_reg_wb | output | 16 | Decremented register value |
| res_wb_en | output | 1 | Write-back strobe for `res_reg_wb` |
| busy | output | 1 | Indirect fetch in progress |
| mem_rd_req | output | 1 | Pointer read request |
| mem_rd_addr | output | 16 | Pointer read address |
| mem_rd_ack | input | 1 | Pointer read acknowledge |
| mem_rd_data | input | 16 | Pointer word, big-endian |

## Verification
The bench aims at the edges of the branch window: displacements 0x7F and 0x80 must land exactly +128 and −126 bytes from the instruction. A design that skips sign extension sends backward branches forward by 256 bytes. A design that leaves bit 0 set on odd word addresses, odd branch targets or odd pointers lands one byte off. Byte pre-decrements of zero and program counters near 0xFFFF check that the arithmetic wraps; a design that saturates or widens the result gives 0x0000 or the wrong low bits. For indirect fetches, the bench varies the acknowledge latency and drives a competing request while the read is open. A design that drops the read early, or that accepts the intruder, shows a wrong address or an extra result pulse.

// File: rtl/oag_pkg.sv
package oag_pkg;
  typedef enum logic [2:0] {
    M_PREDEC    = 3'd0,
    M_ABS_SHORT = 3'd1,
    M_ABS_LONG  = 3'd2,
    M_PC_REL    = 3'd3,
    M_MEM_IND   = 3'd4
  } ea_mode_e;

  typedef enum logic [1:0] {
    S_IDLE     = 2'd0,
    S_READ_PTR = 2'd1,
    S_DONE     = 2'd2
  } seq_state_e;
endpackage

// File: rtl/oag_align.sv
// Clears bit 0 of a value when force_even is set.
module oag_align #(
  parameter int W = 16
) (
  input  logic [W-1:0] din,
  input  logic         force_even,
  output logic [W-1:0] dout
);
  assign dout = {din[W-1:1], din[0] & ~force_even};
endmodule

// File: rtl/oag_direct_calc.sv
// Combinational address forming for every mode that needs no memory read,
// plus the aligned pointer address for the indirect mode.
module oag_direct_calc
  import oag_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic [2:0]        mode,
  input  logic              is_word,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] field,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] wb_val,
  output logic              wb_en,
  output logic              dir_hit,
  output logic              ind_hit,
  output logic [ADDR_W-1:0] ptr_addr
);
  localparam int HI_W = ADDR_W - SHORT_W;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [HI_W-1:0]   TOP_PAGE  = {HI_W{1'b1}};
  localparam logic [HI_W-1:0]   ZERO_PAGE = {HI_W{1'b0}};

  ea_mode_e          m;
  logic [ADDR_W-1:0] raw_addr;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] dec_val;
  logic [ADDR_W-1:0] disp_ext;
  logic              force_even;

  assign m        = ea_mode_e'(mode);
  assign step     = is_word ? (ONE << 1) : ONE;
  assign dec_val  = reg_val - step;
  assign disp_ext = {{HI_W{field[SHORT_W-1]}}, field[SHORT_W-1:0]};

  always_comb begin
    raw_addr   = '0;
    force_even = 1'b0;
    wb_en      = 1'b0;
    dir_hit    = 1'b0;
    ind_hit    = 1'b0;
    case (m)
      M_PREDEC: begin
        raw_addr   = dec_val;
        force_even = is_word;
        wb_en      = 1'b1;
        dir_hit    = 1'b1;
      end
      M_ABS_SHORT: begin
        raw_addr   = {TOP_PAGE, field[SHORT_W-1:0]};
        force_even = is_word;
        dir_hit    = 1'b1;
      end
      M_ABS_LONG: begin
        raw_addr   = field;
        force_even = is_word;
        dir_hit    = 1'b1;
      end
      M_PC_REL: begin
        raw_addr   = pc + disp_ext;
        force_even = 1'b1;
        dir_hit    = 1'b1;
      end
      M_MEM_IND: begin
        ind_hit    = 1'b1;
      end
      default: begin
        dir_hit    = 1'b0;
      end
    endcase
  end

  assign wb_val = dec_val;

  oag_align #(.W(ADDR_W)) u_align_dir (
    .din        (raw_addr),
    .force_even (force_even),
    .dout       (addr)
  );

  oag_align #(.W(ADDR_W)) u_align_ptr (
    .din        ({ZERO_PAGE, field[SHORT_W-1:0]}),
    .force_even (1'b1),
    .dout       (ptr_addr)
  );
endmodule

// File: rtl/oag_ind_seq.sv
// Pointer fetch sequencer for the memory-indirect mode.
module oag_ind_seq
  import oag_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic              mem_rd_ack,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] target
);
  seq_state_e        state;
  logic [ADDR_W-1:0] data_even;

  oag_align #(.W(ADDR_W)) u_align_tgt (
    .din        (mem_rd_data),
    .force_even (1'b1),
    .dout       (data_even)
  );

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      done        <= 1'b0;
      target      <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          done <= 1'b0;
          if (start) begin
            state       <= S_READ_PTR;
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= ptr_addr;
          end
        end
        S_READ_PTR: begin
          if (mem_rd_ack) begin
            state      <= S_DONE;
            mem_rd_req <= 1'b0;
            done       <= 1'b1;
            target     <= data_even;
          end
        end
        S_DONE: begin
          done  <= 1'b0;
          state <= S_IDLE;
        end
        default: begin
          state      <= S_IDLE;
          mem_rd_req <= 1'b0;
          done       <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/opnd_ea_unit.sv
module opnd_ea_unit #(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [ADDR_W-1:0] req_field,
  input  logic [ADDR_W-1:0] req_pc,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_addr,
  output logic [ADDR_W-1:0] res_reg_wb,
  output logic              res_wb_en,
  output logic              busy,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [ADDR_W-1:0] mem_rd_data
);
  logic [ADDR_W-1:0] c_addr;
  logic [ADDR_W-1:0] c_wb;
  logic              c_wb_en;
  logic              c_dir;
  logic              c_ind;
  logic [ADDR_W-1:0] c_ptr;
  logic              accept;
  logic              ind_done;
  logic [ADDR_W-1:0] ind_target;
  logic              dir_valid_q;
  logic [ADDR_W-1:0] dir_addr_q;
  logic [ADDR_W-1:0] wb_q;
  logic              wb_en_q;

  oag_direct_calc #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_calc (
    .mode     (req_mode),
    .is_word  (req_word),
    .reg_val  (req_reg),
    .field    (req_field),
    .pc       (req_pc),
    .addr     (c_addr),
    .wb_val   (c_wb),
    .wb_en    (c_wb_en),
    .dir_hit  (c_dir),
    .ind_hit  (c_ind),
    .ptr_addr (c_ptr)
  );

  assign accept = req_valid && !busy;

  oag_ind_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (accept && c_ind),
    .ptr_addr    (c_ptr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_data (mem_rd_data),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .busy        (busy),
    .done        (ind_done),
    .target      (ind_target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_valid_q <= 1'b0;
      dir_addr_q  <= '0;
      wb_q        <= '0;
      wb_en_q     <= 1'b0;
    end else begin
      dir_valid_q <= accept && c_dir;
      wb_en_q     <= accept && c_dir && c_wb_en;
      if (accept && c_dir) begin
        dir_addr_q <= c_addr;
        wb_q       <= c_wb;
      end
    end
  end

  assign res_valid  = dir_valid_q || ind_done;
  assign res_addr   = dir_valid_q ? dir_addr_q : ind_target;
  assign res_reg_wb = wb_q;
  assign res_wb_en  = wb_en_q;
endmodule

// File: rtl/opnd_ea_unit_chk.sv
module opnd_ea_unit_chk #(
  parameter int ADDR_W  = 16,
  parameter int SHORT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              res_valid,
  input logic              res_wb_en,
  input logic [ADDR_W-1:0] res_addr,
  input logic [ADDR_W-1:0] res_reg_wb,
  input logic              mem_rd_req,
  input logic              mem_rd_ack,
  input logic [ADDR_W-1:0] mem_rd_addr
);
  a_r1_wb_tracks_addr: assert property (@(posedge clk) disable iff (rst)
    res_wb_en |-> (res_addr[ADDR_W-1:1] == res_reg_wb[ADDR_W-1:1]));

  a_r7_wb_only_with_result: assert property (@(posedge clk) disable iff (rst)
    res_wb_en |-> res_valid);

  a_r5_read_held: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  a_r5_ack_gives_result: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && mem_rd_ack) |=> (res_valid && !mem_rd_req && busy));

  a_r5_ptr_zero_page: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> (mem_rd_addr[ADDR_W-1:SHORT_W] == '0 && !mem_rd_addr[0]));

  a_r8_busy_while_reading: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> busy);

  a_r10_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && !mem_rd_req && !busy));
endmodule

bind opnd_ea_unit opnd_ea_unit_chk #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .res_valid   (res_valid),
  .res_wb_en   (res_wb_en),
  .res_addr    (res_addr),
  .res_reg_wb  (res_reg_wb),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_ack  (mem_rd_ack),
  .mem_rd_addr (mem_rd_addr)
);

// File: tb/opnd_ea_unit_bench.sv
`timescale 1ns/1ps
module opnd_ea_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = 3'd0;
  logic        req_word = 1'b0;
  logic [15:0] req_reg = '0;
  logic [15:0] req_field = '0;
  logic [15:0] req_pc = '0;
  logic        res_valid;
  logic [15:0] res_addr;
  logic [15:0] res_reg_wb;
  logic        res_wb_en;
  logic        busy;
  logic        mem_rd_req;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_ack = 1'b0;
  logic [15:0] mem_rd_data = '0;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  logic [7:0] zmem [256];

  always #4 clk = ~clk;

  opnd_ea_unit u_opnd_ea_unit (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_mode (req_mode),
    .req_word (req_word), .req_reg (req_reg), .req_field (req_field),
    .req_pc (req_pc), .res_valid (res_valid), .res_addr (res_addr),
    .res_reg_wb (res_reg_wb), .res_wb_en (res_wb_en), .busy (busy),
    .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack (mem_rd_ack), .mem_rd_data (mem_rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(input logic [2:0] m, input bit w,
      input logic [15:0] rv, input logic [15:0] f, input logic [15:0] pc);
    logic [15:0] a;
    bit          ev;
    a = '0; ev = 1'b0;
    case (m)
      3'd0: begin a = rv - (w ? 16'd2 : 16'd1); ev = w; end
      3'd1: begin a = {8'hFF, f[7:0]}; ev = w; end
      3'd2: begin a = f; ev = w; end
      3'd3: begin a = pc + {{8{f[7]}}, f[7:0]}; ev = 1'b1; end
      default: a = '0;
    endcase
    if (ev) a[0] = 1'b0;
    return a;
  endfunction

  task automatic run_direct(input logic [2:0] m, input bit w, input logic [15:0] rv,
      input logic [15:0] f, input logic [15:0] pc, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_word = w;
    req_reg = rv; req_field = f; req_pc = pc;
    @(negedge clk);
    req_valid = 1'b0;
    if (m <= 3'd3) begin
      check(res_valid == 1'b1, {tag, " R7 valid"}, 32'(res_valid), 32'd1);
      check(res_addr == exp_addr(m, w, rv, f, pc), tag, 32'(res_addr),
            32'(exp_addr(m, w, rv, f, pc)));
      check(res_wb_en == (m == 3'd0), {tag, " R7 wb_en"}, 32'(res_wb_en),
            32'(m == 3'd0));
      if (m == 3'd0)
        check(res_reg_wb == rv - (w ? 16'd2 : 16'd1), {tag, " R1 wb value"},
              32'(res_reg_wb), 32'(rv - (w ? 16'd2 : 16'd1)));
    end else begin
      check(!res_valid && !res_wb_en && !mem_rd_req && !busy, {tag, " R9 unused mode"},
            {28'd0, res_valid, res_wb_en, mem_rd_req, busy}, 32'd0);
    end
    @(negedge clk);
    check(res_valid == 1'b0, {tag, " R7 single pulse"}, 32'(res_valid), 32'd0);
  endtask

  task automatic run_indirect(input logic [7:0] f, input int lat, input bit intrude);
    logic [7:0]  p;
    logic [15:0] word;
    p = {f[7:1], 1'b0};
    word = {zmem[p], zmem[p + 8'd1]};
    @(negedge clk);
    req_valid = 1'b1; req_mode = 3'd4; req_word = 1'b1; req_field = {8'h5A, f};
    @(negedge clk);
    req_valid = intrude; req_mode = 3'd2; req_field = 16'h1234;
    check(busy == 1'b1, "R8 busy during read", 32'(busy), 32'd1);
    check(mem_rd_req == 1'b1, "R5 read request", 32'(mem_rd_req), 32'd1);
    check(mem_rd_addr == {8'h00, p}, "R5 pointer address", 32'(mem_rd_addr),
          32'({8'h00, p}));
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check(mem_rd_req && mem_rd_addr == {8'h00, p} && !res_valid, "R5 request held",
            {15'd0, mem_rd_req, mem_rd_addr}, {15'd1, 8'h00, p});
    end
    mem_rd_ack = 1'b1; mem_rd_data = word;
    @(negedge clk);
    mem_rd_ack = 1'b0; req_valid = 1'b0;
    check(res_valid == 1'b1, "R5 result valid", 32'(res_valid), 32'd1);
    check(res_addr == {word[15:1], 1'b0}, "R5 R6 indirect target", 32'(res_addr),
          32'({word[15:1], 1'b0}));
    check(!res_wb_en && !mem_rd_req && busy, "R8 done state",
          {29'd0, res_wb_en, mem_rd_req, busy}, 32'd1);
    @(negedge clk);
    check(!res_valid && !busy && !mem_rd_req, "R8 intruder ignored",
          {29'd0, res_valid, busy, mem_rd_req}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) zmem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(!res_valid && !res_wb_en && !busy && !mem_rd_req, "R10 reset state",
          {28'd0, res_valid, res_wb_en, busy, mem_rd_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!res_valid && !busy && !mem_rd_req, "R10 after release",
          {29'd0, res_valid, busy, mem_rd_req}, 32'd0);

    run_direct(3'd0, 1'b0, 16'h1001, 16'h0, 16'h0, "R1 byte predec");
    run_direct(3'd0, 1'b1, 16'h2000, 16'h0, 16'h0, "R1 word predec");
    run_direct(3'd0, 1'b1, 16'h2003, 16'h0, 16'h0, "R1 R6 odd word predec");
    run_direct(3'd0, 1'b0, 16'h0000, 16'h0, 16'h0, "R11 predec wrap");
    run_direct(3'd1, 1'b0, 16'h0, 16'hAB37, 16'h0, "R2 short abs byte");
    run_direct(3'd1, 1'b1, 16'h0, 16'h00FF, 16'h0, "R2 R6 short abs word");
    run_direct(3'd2, 1'b0, 16'h0, 16'h8765, 16'h0, "R3 long abs byte");
    run_direct(3'd2, 1'b1, 16'h0, 16'h8765, 16'h0, "R3 R6 long abs word");
    run_direct(3'd3, 1'b0, 16'h0, 16'h007F, 16'h1002, "R4 forward limit");
    run_direct(3'd3, 1'b0, 16'h0, 16'h0080, 16'h1002, "R4 backward limit");
    run_direct(3'd3, 1'b1, 16'h0, 16'h007F, 16'hFFF0, "R11 R4 pc wrap");
    run_direct(3'd5, 1'b1, 16'h1111, 16'h2222, 16'h3333, "R9 code 5");
    run_direct(3'd7, 1'b0, 16'h1111, 16'h2222, 16'h3333, "R9 code 7");

    run_indirect(8'h10, 0, 1'b0);
    run_indirect(8'h21, 2, 1'b1);
    run_indirect(8'hFF, 3, 1'b1);

    for (int n = 0; n < 300; n++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 5));
      if (m == 3'd4)
        run_indirect(8'($urandom), int'($urandom_range(0, 3)), 1'($urandom));
      else
        run_direct(m, 1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                   "R1 R2 R3 R4 R6 random");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule